// File: doc/BRIEF.md
# Board Test XOR Chain Controller

This block wraps the output enables of a 128-pad ring so that board connectivity can be tested. When the test strap input is high, the block is in test mode. In that mode it turns off the output drivers of every pad that belongs to the chain. It also drives one shared pad with the running XOR of the chain pads' input values. A board tester can then find an open pad, or a pad shorted to a rail, by toggling pads one at a time and watching a single pin.

When the strap is low, the block is transparent. Every pad's output enable comes straight from the core, and the shared pad carries its normal serial modem control signal. The path from pad inputs to the shared pad is purely combinational, so test mode needs no clock. Mode changes take effect as soon as the strap level changes, and nothing is latched.

Top module: `brd_xor_chain`

## Requirements
- R1: Test mode is active exactly while `test_strap_i` is 1. When the strap returns to 0, all outputs follow the normal-mode rules at once, with no memory of the earlier test state.
- R2: In test mode, `pad_oe_o[i]` is 0 for every chain pad i, whatever `core_oe_i[i]` is.
- R3: In test mode, `pad_oe_o[29]` (pad 30, the shared chain output pad) is 1, even when `core_oe_i[29]` is 0.
- R4: Outside test mode, `pad_oe_o` equals `core_oe_i` on every bit.
- R5: Outside test mode, `chain_pad_o` equals `core_modem_ctl_i`.
- R6: In test mode, `chain_pad_o` is the XOR of `pad_in_i` over all chain pads, and `core_modem_ctl_i` has no effect on it.
- R7: Bit i of each pad vector belongs to pad number i+1. Pads 7, 15, 20, 26, 30, 38, 44, 51, 56, 63, 69, 75, 81, 88, 94, 99, 104, 110, 113, 117, 120, 124 and 127 are excluded. The other 105 pads, from pad 1 up to pad 128, form the chain.
- R8: In test mode, flipping any single chain pad input flips `chain_pad_o`. Flipping any excluded pad input leaves `chain_pad_o` unchanged.
- R9: In test mode, when every chain input is at the same level, `chain_pad_o` equals that level, because the chain length is odd.
- R10: In test mode, `pad_oe_o[i]` equals `core_oe_i[i]` for every excluded pad except pad 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_strap_i | input | 1 | Board strap; 1 selects XOR chain test mode |
| core_oe_i | input | 128 | Normal output enables from the core, bit i = pad i+1 |
| pad_in_i | input | 128 | Input values seen at the pads, bit i = pad i+1 |
| core_modem_ctl_i | input | 1 | Normal-mode data for the shared pad 30 |
| pad_oe_o | output | 128 | Output enables driven to the pad ring |
| chain_pad_o | output | 1 | Data driven onto pad 30 |

## Verification
Assertions are evaluated on every input change. They check four properties: chain pads are disabled in test mode, the shared pad is enabled in test mode, every enable passes through outside test mode, and the shared pad's data matches the chain parity or the normal signal according to the mode. Some properties can only be shown by the bench's scenarios. These are the exact membership of the chain, the observation that each of the 105 members flips the result and each of the 23 excluded pads does not, the all-equal-level outcome, and the absence of state when the strap toggles between cycles.

// File: rtl/xtc_pkg.sv
`timescale 1ns/1ps
package xtc_pkg;
  localparam int PAD_CNT       = 128;
  localparam int EXCL_CNT      = 23;
  localparam int CHAIN_OUT_PAD = 30;

  // pad numbers (1-based) left out of the chain
  localparam int EXCL_PADS [EXCL_CNT] = '{
    7, 15, 20, 26, 30, 38, 44, 51, 56, 63, 69, 75,
    81, 88, 94, 99, 104, 110, 113, 117, 120, 124, 127
  };

  function automatic logic [PAD_CNT-1:0] chain_mask_f();
    logic [PAD_CNT-1:0] m;
    m = '1;
    for (int k = 0; k < EXCL_CNT; k++) m[EXCL_PADS[k]-1] = 1'b0;
    return m;
  endfunction

  localparam logic [PAD_CNT-1:0] CHAIN_MASK = chain_mask_f();
endpackage

// File: rtl/xtc_xor_chain.sv
`timescale 1ns/1ps
module xtc_xor_chain #(
  parameter int                  NUM_PADS = xtc_pkg::PAD_CNT,
  parameter logic [NUM_PADS-1:0] MASK     = xtc_pkg::CHAIN_MASK
) (
  input  logic [NUM_PADS-1:0] pad_i,
  output logic                chain_o
);
  logic [NUM_PADS:0] stage;

  assign stage[0] = 1'b0;

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_stage
    if (MASK[i]) begin : g_member
      assign stage[i+1] = stage[i] ^ pad_i[i];
    end else begin : g_skip
      assign stage[i+1] = stage[i];
    end
  end

  assign chain_o = stage[NUM_PADS];

  // R6: serial cascade must agree with a flat parity of member pads
  always_comb begin
    if (!$isunknown(pad_i)) begin
      a_r6_chain_parity: assert (chain_o === ^(pad_i & MASK))
        else $error("chain cascade disagrees with member parity");
    end
  end
endmodule

// File: rtl/xtc_oe_override.sv
`timescale 1ns/1ps
module xtc_oe_override #(
  parameter int                  NUM_PADS = xtc_pkg::PAD_CNT,
  parameter int                  OUT_IDX  = xtc_pkg::CHAIN_OUT_PAD - 1,
  parameter logic [NUM_PADS-1:0] MASK     = xtc_pkg::CHAIN_MASK
) (
  input  logic                test_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  output logic [NUM_PADS-1:0] oe_o
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_oe
    if (i == OUT_IDX) begin : g_out
      assign oe_o[i] = test_i | core_oe_i[i];
    end else if (MASK[i]) begin : g_member
      assign oe_o[i] = ~test_i & core_oe_i[i];
    end else begin : g_pass
      assign oe_o[i] = core_oe_i[i];
    end
  end

  always_comb begin
    if (test_i === 1'b1) begin
      a_r2_chain_hiz: assert ((oe_o & MASK) === '0)
        else $error("chain pad driving in test mode");
      a_r3_out_oe_on: assert (oe_o[OUT_IDX] === 1'b1)
        else $error("chain output pad not enabled in test mode");
    end else if (test_i === 1'b0 && !$isunknown(core_oe_i)) begin
      a_r4_oe_pass: assert (oe_o === core_oe_i)
        else $error("enables altered outside test mode");
    end
  end
endmodule

// File: rtl/xtc_pad_mux.sv
`timescale 1ns/1ps
module xtc_pad_mux (
  input  logic test_i,
  input  logic chain_i,
  input  logic func_i,
  output logic pad_o
);
  assign pad_o = test_i ? chain_i : func_i;

  always_comb begin
    if (test_i === 1'b0 && !$isunknown(func_i)) begin
      a_r5_func_pass: assert (pad_o === func_i)
        else $error("shared pad lost normal signal");
    end else if (test_i === 1'b1 && !$isunknown(chain_i)) begin
      a_r6_chain_sel: assert (pad_o === chain_i)
        else $error("shared pad not carrying chain result");
    end
  end
endmodule

// File: rtl/brd_xor_chain.sv
`timescale 1ns/1ps
module brd_xor_chain #(
  parameter int                  NUM_PADS = xtc_pkg::PAD_CNT,
  parameter int                  OUT_IDX  = xtc_pkg::CHAIN_OUT_PAD - 1,
  parameter logic [NUM_PADS-1:0] MASK     = xtc_pkg::CHAIN_MASK
) (
  input  logic                test_strap_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  input  logic [NUM_PADS-1:0] pad_in_i,
  input  logic                core_modem_ctl_i,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic                chain_pad_o
);
  logic test_mode;
  logic chain_res;

  // level-held strap, no latching (R1)
  assign test_mode = test_strap_i;

  xtc_xor_chain #(
    .NUM_PADS (NUM_PADS),
    .MASK     (MASK)
  ) u_chain (
    .pad_i   (pad_in_i),
    .chain_o (chain_res)
  );

  xtc_oe_override #(
    .NUM_PADS (NUM_PADS),
    .OUT_IDX  (OUT_IDX),
    .MASK     (MASK)
  ) u_oe (
    .test_i    (test_mode),
    .core_oe_i (core_oe_i),
    .oe_o      (pad_oe_o)
  );

  xtc_pad_mux u_mux (
    .test_i  (test_mode),
    .chain_i (chain_res),
    .func_i  (core_modem_ctl_i),
    .pad_o   (chain_pad_o)
  );
endmodule

// File: tb/tb_brd_xor_chain.sv
`timescale 1ns/1ps
module tb_brd_xor_chain;
  localparam int N       = 128;
  localparam int OUT_BIT = 29;

  typedef struct {
    string          req;
    logic [N-1:0]   exp_oe;
    logic           exp_out;
  } item_t;

  logic         clk;
  logic         strap;
  logic [N-1:0] core_oe;
  logic [N-1:0] pad_in;
  logic         modem;
  logic [N-1:0] pad_oe;
  logic         chain_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  item_t sb_q[$];
  logic [N-1:0] tb_mask;

  brd_xor_chain dut (
    .test_strap_i     (strap),
    .core_oe_i        (core_oe),
    .pad_in_i         (pad_in),
    .core_modem_ctl_i (modem),
    .pad_oe_o         (pad_oe),
    .chain_pad_o      (chain_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R7 membership, written independently from the requirement text
  initial begin
    int excl [23] = '{7, 15, 20, 26, 30, 38, 44, 51, 56, 63, 69, 75,
                      81, 88, 94, 99, 104, 110, 113, 117, 120, 124, 127};
    tb_mask = '1;
    foreach (excl[k]) tb_mask[excl[k]-1] = 1'b0;
  end

  function automatic logic [N-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic drive(input logic s, input logic [N-1:0] oe,
                       input logic [N-1:0] pin, input logic m,
                       input string req);
    item_t it;
    @(posedge clk);
    strap = s; core_oe = oe; pad_in = pin; modem = m;
    it.req = req;
    if (s) begin
      it.exp_oe = (oe & ~tb_mask);
      it.exp_oe[OUT_BIT] = 1'b1;
      it.exp_out = ^(pin & tb_mask);
    end else begin
      it.exp_oe  = oe;
      it.exp_out = m;
    end
    sb_q.push_back(it);
  endtask

  task automatic drive_exp(input logic s, input logic [N-1:0] oe,
                           input logic [N-1:0] pin, input logic m,
                           input logic eo, input string req);
    item_t it;
    @(posedge clk);
    strap = s; core_oe = oe; pad_in = pin; modem = m;
    it.req = req;
    it.exp_oe = (oe & ~tb_mask);
    it.exp_oe[OUT_BIT] = 1'b1;
    it.exp_out = eo;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (pad_oe !== it.exp_oe || chain_out !== it.exp_out) begin
        bad++;
        $display("FAIL %s: oe=%h out=%b expected oe=%h out=%b",
                 it.req, pad_oe, chain_out, it.exp_oe, it.exp_out);
      end
    end
  end

  initial begin
    strap = 1'b0; core_oe = '0; pad_in = '0; modem = 1'b0;
    // reset / idle state: normal mode, everything passes (R4, R5)
    drive(1'b0, '0, '0, 1'b0, "R4 idle");
    drive(1'b0, '1, '1, 1'b1, "R5 all ones normal");
    for (int k = 0; k < 6; k++)
      drive(1'b0, rnd128(), rnd128(), k[0], "R4 R5 random normal");
    // test mode enables (R2, R3, R10)
    drive(1'b1, '1, '0, 1'b1, "R2 R10 all enables set");
    begin
      logic [N-1:0] oe_n;
      oe_n = '1; oe_n[OUT_BIT] = 1'b0;
      drive(1'b1, oe_n, '0, 1'b0, "R3 out pad forced on");
    end
    // equal levels (R9)
    drive_exp(1'b1, '0, '0, 1'b1, 1'b0, "R9 all low");
    drive_exp(1'b1, '0, '1, 1'b0, 1'b1, "R9 all high");
    drive_exp(1'b1, '0, tb_mask, 1'b0, 1'b1, "R9 members high only");
    // single-pad toggles (R7, R8)
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] v;
      v = '0; v[p] = 1'b1;
      drive_exp(1'b1, rnd128(), v, p[0], tb_mask[p], "R7 R8 single pad");
    end
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] v;
      v = '1; v[p] = 1'b0;
      drive_exp(1'b1, '0, v, 1'b1, ~tb_mask[p], "R8 single pad low");
    end
    // random test patterns, modem ignored (R6)
    for (int k = 0; k < 16; k++)
      drive(1'b1, rnd128(), rnd128(), k[1], "R6 random test");
    // strap toggling every cycle, no memory (R1)
    for (int k = 0; k < 10; k++)
      drive(k[0], rnd128(), rnd128(), k[1], "R1 strap toggle");
    drive(1'b0, '1, '1, 1'b0, "R1 exit test");
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule